// File: doc/BRIEF.md
# Dual-Protocol Host Bus Slave

This block sits between an external microprocessor bus and a small bank of 8-bit configuration registers. One set of host pins carries two bus styles, chosen by a static mode input. In mode 0 the host uses two active-low strobes, one for write and one for read. In mode 1 the host uses an active-low address strobe, an active-low data strobe, and a level that is high for a read and low for a write. Chip select is active low in both modes. The pins that change meaning between the modes are `hstb_n` and `hrw`.

Every host pin is asynchronous to the block clock. The block passes the pins through a two-flop synchroniser and finds strobe edges on the synchronised copies. It passes the address and data buses through a matching register pipeline, so that they line up with those edges. Writes commit on the rising (trailing) edge of the write or data strobe. Read data is placed on a tri-state data bus, and the block then acknowledges it. The acknowledge stays asserted until the host ends the access.

Top module: `dual_host_bus_if`

## Requirements
- R1: After reset, `hdata_oe` is 0, `hack_n` is 1, `hwait_n` is 1, and every register reads back as 0x00.
- R2: In mode 0 (`mode_i`=0), a write needs `hcs_n` low and `hrw` (the read strobe) high. The falling edge of `hstb_n` captures `haddr`. The rising edge of `hstb_n` writes the `hdata` value into that register.
- R3: In mode 0, a falling edge of `hrw` while `hstb_n` is high and `hcs_n` is low captures `haddr`. It then places the addressed register on `hdata`.
- R4: In mode 1 (`mode_i`=1), the falling edge of `has_n` with `hcs_n` low captures `haddr`. A write needs `hrw` low. It commits the `hdata` value on the rising edge of `hstb_n` (the data strobe).
- R5: In mode 1, a read starts when `hcs_n`, `has_n` and `hstb_n` are all low and `hrw` is high. It places the register whose address was captured on `hdata`.
- R6: A read start becomes `hdata_oe`=1 three clock edges after the strobe pin falls. `hack_n` falls one clock later. `hwait_n` is low for exactly that one cycle between them, and it is never low together with `hack_n`.
- R7: `hdata_oe` and `hack_n`=0 stay asserted while the read strobe condition holds. Both drop three clock edges after that condition ends.
- R8: Any strobe activity with `hcs_n` high is ignored: no register changes, and the data bus is not driven.
- R9: `hdata` is driven only while `hdata_oe` is 1. During write cycles `hdata_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Bus style: 0 = separate read/write strobes, 1 = address strobe + data strobe + direction |
| hcs_n | input | 1 | Active-low chip select |
| has_n | input | 1 | Active-low address strobe (mode 1 only) |
| hstb_n | input | 1 | Mode 0: active-low write strobe; mode 1: active-low data strobe |
| hrw | input | 1 | Mode 0: active-low read strobe; mode 1: 1 = read, 0 = write |
| haddr | input | AW (4) | Register address |
| hdata | inout | DW (8) | Bidirectional data bus, high-impedance unless a read is served |
| hdata_oe | output | 1 | Pad output enable for the data bus |
| hack_n | output | 1 | Active-low read data valid acknowledge |
| hwait_n | output | 1 | Active-low wait, low while read data is settling |

## Verification
A wrong address latch, for example one taken at the wrong strobe edge or in the wrong mode, shows only later. The wrong register is updated, and the error appears on `hdata` at the next read of either address. The bench therefore always reads back through the other mode, so errors from both protocols meet in one reference model. A stuck or misordered read controller shows within four or five clocks of a strobe edge, as a wrong `hdata_oe`, `hack_n` or `hwait_n` cycle count. A missing chip-select gate shows either as a drive during an unselected read or as a changed value on the next selected read of that address.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_DRIVE = 2'd1,
    RD_ACK   = 2'd2
  } rd_state_e;

  // synchronised host control pins, all idle high
  typedef struct packed {
    logic cs_n;
    logic as_n;
    logic stb_n;
    logic rw;
  } pins_t;

  localparam int unsigned PIN_W = $bits(pins_t);

  function automatic logic fell_f(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  function automatic logic rose_f(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction

  // strobe/direction style: read window is open
  function automatic logic sd_read_f(input pins_t p);
    return ~p.cs_n & ~p.as_n & ~p.stb_n & p.rw;
  endfunction
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RSTV  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= RSTV;
        else        st[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= RSTV;
        else        st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/hbi_decode.sv
module hbi_decode
  import hbi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_i,
  input  pins_t cur,
  input  pins_t prv,
  output logic  addr_cap,
  output logic  wr_commit,
  output logic  rd_start,
  output logic  rd_hold
);
  timeunit 1ns;
  timeprecision 100ps;

  logic sel;
  logic arm_set;
  logic armed_q;

  always_comb begin
    sel = ~cur.cs_n;
    if (!mode_i) begin
      // separate strobes: stb_n writes, rw is the active-low read strobe
      arm_set   = sel & fell_f(prv.stb_n, cur.stb_n) & cur.rw;
      rd_start  = sel & fell_f(prv.rw, cur.rw) & cur.stb_n;
      addr_cap  = arm_set | rd_start;
      wr_commit = sel & armed_q & rose_f(prv.stb_n, cur.stb_n) & cur.rw;
      rd_hold   = sel & ~cur.rw;
    end else begin
      // address strobe, data strobe and direction level
      arm_set   = sel & fell_f(prv.stb_n, cur.stb_n) & ~cur.as_n & ~cur.rw;
      addr_cap  = sel & fell_f(prv.as_n, cur.as_n);
      rd_hold   = sd_read_f(cur);
      rd_start  = sd_read_f(cur) & ~sd_read_f(prv);
      wr_commit = sel & armed_q & rose_f(prv.stb_n, cur.stb_n) & ~cur.rw;
    end
  end

  // a write may only commit after its opening edge was seen while selected
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                armed_q <= 1'b0;
    else if (!sel || wr_commit) armed_q <= 1'b0;
    else if (arm_set)          armed_q <= 1'b1;
  end
endmodule

// File: rtl/hbi_rdctl.sv
module hbi_rdctl
  import hbi_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned ACK_DLY = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_start,
  input  logic          rd_hold,
  input  logic [DW-1:0] rdata_in,
  output logic [DW-1:0] dout,
  output logic          oe,
  output logic          ack_n,
  output logic          wait_n
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned CW = (ACK_DLY < 2) ? 1 : $clog2(ACK_DLY);

  rd_state_e     state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      cnt_q   <= '0;
      dout    <= '0;
    end else begin
      case (state_q)
        RD_IDLE: if (rd_start) begin
          state_q <= RD_DRIVE;
          dout    <= rdata_in;
          cnt_q   <= CW'(ACK_DLY - 1);
        end
        RD_DRIVE: begin
          if (!rd_hold)         state_q <= RD_IDLE;
          else if (cnt_q == '0) state_q <= RD_ACK;
          else                  cnt_q   <= cnt_q - 1'b1;
        end
        RD_ACK: if (!rd_hold) state_q <= RD_IDLE;
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign oe     = (state_q != RD_IDLE);
  assign ack_n  = (state_q != RD_ACK);
  assign wait_n = (state_q != RD_DRIVE);
endmodule

// File: rtl/hbi_regfile.sv
module hbi_regfile #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dual_host_bus_if.sv
module dual_host_bus_if
  import hbi_pkg::*;
#(
  parameter int unsigned AW          = 4,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ACK_DLY     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_i,
  input  logic          hcs_n,
  input  logic          has_n,
  input  logic          hstb_n,
  input  logic          hrw,
  input  logic [AW-1:0] haddr,
  inout  wire  [DW-1:0] hdata,
  output logic          hdata_oe,
  output logic          hack_n,
  output logic          hwait_n
);
  timeunit 1ns;
  timeprecision 100ps;

  pins_t         pin_raw;
  pins_t         pin_s;
  pins_t         pin_p;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] raddr;
  logic [DW-1:0] rf_rdata;
  logic [DW-1:0] rd_dout;

  // named internal events, observed by the checker
  logic sel_s;
  logic ev_addr_cap;
  logic ev_wr_commit;
  logic ev_rd_start;
  logic rd_hold;

  assign pin_raw = '{cs_n: hcs_n, as_n: has_n, stb_n: hstb_n, rw: hrw};

  hbi_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RSTV({PIN_W{1'b1}})) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
  );

  hbi_sync #(.W(AW), .STAGES(SYNC_STAGES), .RSTV('0)) u_addr_pipe (
    .clk(clk), .rst_n(rst_n), .d(haddr), .q(addr_s)
  );

  hbi_sync #(.W(DW), .STAGES(SYNC_STAGES), .RSTV('0)) u_data_pipe (
    .clk(clk), .rst_n(rst_n), .d(hdata), .q(data_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_p <= '1;
    else        pin_p <= pin_s;
  end

  assign sel_s = ~pin_s.cs_n;

  hbi_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .cur      (pin_s),
    .prv      (pin_p),
    .addr_cap (ev_addr_cap),
    .wr_commit(ev_wr_commit),
    .rd_start (ev_rd_start),
    .rd_hold  (rd_hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           addr_q <= '0;
    else if (ev_addr_cap) addr_q <= addr_s;
  end

  // address latch and read start may share a cycle: bypass the latch
  assign raddr = ev_addr_cap ? addr_s : addr_q;

  hbi_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (ev_wr_commit),
    .waddr(addr_q),
    .wdata(data_s),
    .raddr(raddr),
    .rdata(rf_rdata)
  );

  hbi_rdctl #(.DW(DW), .ACK_DLY(ACK_DLY)) u_rdctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_start(ev_rd_start),
    .rd_hold (rd_hold),
    .rdata_in(rf_rdata),
    .dout    (rd_dout),
    .oe      (hdata_oe),
    .ack_n   (hack_n),
    .wait_n  (hwait_n)
  );

  assign hdata = hdata_oe ? rd_dout : {DW{1'bz}};
endmodule

// File: rtl/hbi_checks.sv
module hbi_checks (
  input logic clk,
  input logic rst_n,
  input logic sel_s,
  input logic ev_rd_start,
  input logic ev_wr_commit,
  input logic rd_hold,
  input logic hdata_oe,
  input logic hack_n,
  input logic hwait_n
);
  timeunit 1ns;
  timeprecision 100ps;

  AST_UNSELECTED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> !hdata_oe); // R8

  AST_START_OPENS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_start |=> (hdata_oe && !hwait_n && hack_n)); // R6

  AST_ACK_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hack_n) |-> $past(hdata_oe)); // R6

  AST_WAIT_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !hwait_n |-> (hack_n && hdata_oe)); // R6

  AST_DRIVE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdata_oe) |-> $past(ev_rd_start)); // R9

  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hack_n && rd_hold) |=> !hack_n); // R7

  AST_RELEASE_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (hdata_oe && !rd_hold) |=> (!hdata_oe && hack_n)); // R7

  AST_WRITE_NOT_DURING_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_commit |-> !rd_hold); // R9
endmodule

bind dual_host_bus_if hbi_checks u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_s       (sel_s),
  .ev_rd_start (ev_rd_start),
  .ev_wr_commit(ev_wr_commit),
  .rd_hold     (rd_hold),
  .hdata_oe    (hdata_oe),
  .hack_n      (hack_n),
  .hwait_n     (hwait_n)
);

// File: tb/test_dual_host_bus_if.sv
module test_dual_host_bus_if;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i = 1'b0;
  logic hcs_n = 1'b1;
  logic has_n = 1'b1;
  logic hstb_n = 1'b1;
  logic hrw = 1'b1;
  logic [AW-1:0] haddr = '0;
  logic tb_drv = 1'b0;
  logic [DW-1:0] tb_d = '0;
  wire  [DW-1:0] hdata;
  logic hdata_oe, hack_n, hwait_n;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] model [DEPTH];

  assign hdata = tb_drv ? tb_d : {DW{1'bz}};

  always #2.5 clk = ~clk;

  dual_host_bus_if i_dual_host_bus_if (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .hcs_n(hcs_n), .has_n(has_n),
    .hstb_n(hstb_n), .hrw(hrw), .haddr(haddr), .hdata(hdata),
    .hdata_oe(hdata_oe), .hack_n(hack_n), .hwait_n(hwait_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected pin-to-output latencies, from the requirements
  function automatic int exp_oe_lat();  return 3; endfunction
  function automatic int exp_ack_lat(); return exp_oe_lat() + 1; endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    hcs_n = 1'b1; has_n = 1'b1; hstb_n = 1'b1; hrw = 1'b1; tb_drv = 1'b0;
    cyc(4);
  endtask

  // write; stb_n edges commit in both modes
  task automatic do_write(input logic m, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic sel);
    int seen_oe = 0;
    @(negedge clk);
    mode_i = m; haddr = a; tb_d = d; tb_drv = 1'b1; hcs_n = ~sel;
    if (m) hrw = 1'b0;
    cyc(1);
    if (m) begin has_n = 1'b0; cyc(1); end
    hstb_n = 1'b0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); seen_oe |= int'(hdata_oe); end
    hstb_n = 1'b1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); seen_oe |= int'(hdata_oe); end
    chk(m ? "R9 no drive in mode-1 write" : "R9 no drive in mode-0 write", seen_oe, 0);
    if (sel) model[a] = d;
    go_idle();
  endtask

  task automatic do_read(input logic m, input logic [AW-1:0] a,
                         input logic sel, input string tag);
    int f_oe = 0, f_ack = 0, n_wait = 0, f_rel = 0, both = 0;
    logic [DW-1:0] got = '0;
    @(negedge clk);
    mode_i = m; haddr = a; hcs_n = ~sel; hrw = m ? 1'b1 : 1'b1;
    cyc(1);
    if (m) begin has_n = 1'b0; cyc(1); hstb_n = 1'b0; end
    else   hrw = 1'b0;
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      if (hdata_oe && f_oe == 0) f_oe = i;
      if (!hack_n && f_ack == 0) f_ack = i;
      if (!hwait_n) n_wait++;
      if (!hwait_n && !hack_n) both++;
    end
    if (hdata_oe) got = hdata;
    if (sel) begin
      chk({tag, " R6 drive latency"}, f_oe, exp_oe_lat());
      chk({tag, " R6 ack latency"}, f_ack, exp_ack_lat());
      chk({tag, " R6 wait cycles"}, n_wait, 1);
      chk({tag, " R6 wait/ack overlap"}, both, 0);
      chk({tag, " R7 ack held"}, int'(hack_n), 0);
      chk({tag, m ? " R5 read data" : " R3 read data"}, int'(got), int'(model[a]));
      if (m) hstb_n = 1'b1; else hrw = 1'b1;
      for (int i = 1; i <= 5; i++) begin
        @(negedge clk);
        if (!hdata_oe && f_rel == 0) f_rel = i;
      end
      chk({tag, " R7 release latency"}, f_rel, 3);
      chk({tag, " R7 ack released"}, int'(hack_n), 1);
    end else begin
      chk({tag, " R8 unselected read not driven"}, f_oe + f_ack + n_wait, 0);
    end
    go_idle();
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    cyc(3);
    chk("R1 oe in reset", int'(hdata_oe), 0);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 oe after reset", int'(hdata_oe), 0);
    chk("R1 ack after reset", int'(hack_n), 1);
    chk("R1 wait after reset", int'(hwait_n), 1);
    do_read(1'b0, 4'd5, 1'b1, "R1 reset value");
    do_read(1'b1, 4'd15, 1'b1, "R1 reset value");

    // directed: boundary addresses, cross-mode readback
    do_write(1'b0, 4'd0, 8'hA5, 1'b1);   // R2
    do_write(1'b0, 4'd15, 8'h3C, 1'b1);  // R2
    do_read(1'b1, 4'd0, 1'b1, "R2 via mode1");
    do_read(1'b1, 4'd15, 1'b1, "R2 via mode1");
    do_write(1'b1, 4'd7, 8'hFF, 1'b1);   // R4
    do_read(1'b0, 4'd7, 1'b1, "R4 via mode0");
    // R8: unselected writes leave the register unchanged
    do_write(1'b0, 4'd7, 8'h11, 1'b0);
    do_write(1'b1, 4'd0, 8'h22, 1'b0);
    do_read(1'b0, 4'd7, 1'b1, "R8 after ignored write");
    do_read(1'b1, 4'd0, 1'b1, "R8 after ignored write");
    do_read(1'b0, 4'd7, 1'b0, "m0");
    do_read(1'b1, 4'd7, 1'b0, "m1");

    // constrained random mix
    for (int t = 0; t < 80; t++) begin
      logic m = 1'($urandom_range(0, 1));
      logic s = ($urandom_range(0, 4) != 0);
      logic [AW-1:0] a = AW'($urandom_range(0, DEPTH - 1));
      if ($urandom_range(0, 1) != 0)
        do_write(m, a, DW'($urandom_range(0, 255)), s);
      else
        do_read(m, a, s, m ? "rand m1" : "rand m0");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule